// File: doc/BRIEF.md
# Outbound MMIO Window Group Decoder

This block classifies each CPU-side MMIO address against a set of programmable address windows. Two kinds exist: a single narrow window, which rewrites the upper address bits, and a bank of wide windows, which leave the address untouched. For every address that falls in some enabled window, the block returns the address to forward onto the I/O bus and the number of the isolation group that owns the access. An address outside all enabled windows is reported as a miss.

Each window is a naturally aligned power-of-two region and is divided into `2**SEG_BITS` equal segments. The narrow window reads each segment's group from a programmable table. A wide window works in one of two ways. In whole mode, one programmed group covers the entire window. In segmented mode, the segment index itself is the group number. Wide windows may overlap each other and the narrow window. A fixed priority picks the winner.

Configuration is written through a simple write-only register port. A request is presented with `req_valid` and `req_addr`, and the decoded result appears on the registered `resp_*` outputs one clock later.

Top module: `mmio_window_decoder`

## Requirements
- R1: After reset every window is disabled, `resp_valid` is 0, and any request decodes as a miss.
- R2: `resp_valid` in a cycle equals `req_valid` of the previous cycle, and the other `resp_*` outputs describe the address presented in that previous cycle.
- R3: A narrow-window hit sets `resp_hit`=1, `resp_wide`=0 and `resp_win`=0. It forwards `(remap & ~(size-1)) | (addr & (size-1))`, where `size` is the window size.
- R4: On a narrow-window hit the group is table entry `(addr - base) >> (log2size - SEG_BITS)`.
- R5: A wide window in whole mode gives `resp_wide`=1, `resp_win`= window number, the programmed group, and `resp_bus_addr` = `req_addr`.
- R6: A wide window in segmented mode gives the group `(addr - base) >> (log2size - SEG_BITS)`, with the bus address untranslated.
- R7: Among overlapping enabled wide windows the lowest-numbered wins. Any wide hit takes precedence over the narrow window.
- R8: A miss gives `resp_hit`=0, `resp_wide`=0, `resp_win`=0, `resp_group`=0 and `resp_bus_addr`=0.
- R9: A written log2 size is clamped into range. For wide windows the range is `W64_MIN_LOG..ADDR_W`. For the narrow window it is `SEG_BITS..W32_LOG_MAX`.
- R10: Base address bits below the window size are ignored, so each window sits at its natural alignment.
- R11: The top segment of the narrow window is reserved for interrupt messages, but it is forwarded like any other segment and is not blocked.
- R12: A disabled window never matches, whatever its base and size.
- R13: `cfg_addr` is `{region[1:0], index}`, where the index field is `max(SEG_BITS, WIN_W)` bits wide. The regions are:
  - Region 0 writes table entry `index` from `wdata[GRP_W-1:0]`.
  - Region 1 writes the base of wide window `index`.
  - Region 2 writes the control of wide window `index`: log2 size in `wdata[LOG_W-1:0]`, segmented mode in bit `LOG_W`, enable in bit `LOG_W+1`, and the group in `wdata[LOG_W+2 +: GRP_W]`.
  - Region 3 writes the narrow window: index 0 is the base, index 1 is the control (log2 size in `wdata[LOG_W-1:0]`, enable in bit `LOG_W`), and index 2 is the remap value.
  - A write affects requests presented from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W+2 | Configuration register select (region, index) |
| cfg_wdata | input | ADDR_W | Configuration write data |
| req_valid | input | 1 | Address request present |
| req_addr | input | ADDR_W | CPU-side address to decode |
| resp_valid | output | 1 | Result valid (request of previous cycle) |
| resp_hit | output | 1 | Address matched an enabled window |
| resp_wide | output | 1 | Winning window is a wide window |
| resp_win | output | WIN_W | Winning wide window number |
| resp_group | output | GRP_W | Isolation group number |
| resp_bus_addr | output | ADDR_W | Address forwarded to the I/O bus |

## Verification
The bench builds the decoder with `ADDR_W`=16, four wide windows, 8 segments per window, 4-bit groups, a narrow window of at most 4 KB, and a minimum wide window of 256 bytes. At that size the whole 64 K address space can be swept, one address per clock, against an arithmetic model. Every overlap boundary, segment edge and window edge is therefore visited, not just sampled. A second configuration, swept at a coarser step, brings in size clamping, unaligned bases, a disabled window and a re-enabled window.

// File: rtl/mmwd_pkg.sv
package mmwd_pkg;

   // Register regions selected by the upper two bits of cfg_addr.
   typedef enum logic [1:0] {
      RGN_TABLE    = 2'd0,
      RGN_W64_BASE = 2'd1,
      RGN_W64_CTRL = 2'd2,
      RGN_W32      = 2'd3
   } cfg_region_e;

   // Sub-indices within the narrow-window region.
   localparam int unsigned W32_SUB_BASE  = 0;
   localparam int unsigned W32_SUB_CTRL  = 1;
   localparam int unsigned W32_SUB_REMAP = 2;

   function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/mmwd_cfg_regs.sv
module mmwd_cfg_regs
   import mmwd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 50,
   parameter int unsigned NUM_WIN64   = 16,
   parameter int unsigned SEG_BITS    = 8,
   parameter int unsigned GRP_W       = 8,
   parameter int unsigned W32_LOG_MAX = 32,
   parameter int unsigned W64_MIN_LOG = 28,
   localparam int unsigned LOG_W      = $clog2(ADDR_W + 1),
   localparam int unsigned WIN_W      = (NUM_WIN64 > 1) ? $clog2(NUM_WIN64) : 1,
   localparam int unsigned IDX_W      = max_u(SEG_BITS, WIN_W),
   localparam int unsigned SEG_COUNT  = 1 << SEG_BITS
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                cfg_we,
   input  logic [IDX_W+1:0]                    cfg_addr,
   input  logic [ADDR_W-1:0]                   cfg_wdata,
   input  logic [SEG_BITS-1:0]                 tbl_idx,
   output logic [GRP_W-1:0]                    tbl_grp,
   output logic [NUM_WIN64-1:0][ADDR_W-1:0]    w64_base,
   output logic [NUM_WIN64-1:0][LOG_W-1:0]     w64_log,
   output logic [NUM_WIN64-1:0]                w64_seg,
   output logic [NUM_WIN64-1:0]                w64_en,
   output logic [NUM_WIN64-1:0][GRP_W-1:0]     w64_grp,
   output logic [ADDR_W-1:0]                   w32_base,
   output logic [LOG_W-1:0]                    w32_log,
   output logic                                w32_en,
   output logic [W32_LOG_MAX-1:0]              w32_remap
);

   cfg_region_e      rgn;
   logic [IDX_W-1:0] idx;

   assign rgn = cfg_region_e'(cfg_addr[IDX_W +: 2]);
   assign idx = cfg_addr[IDX_W-1:0];

   function automatic logic [LOG_W-1:0] clamp_log(input logic [LOG_W-1:0] v,
                                                  input int unsigned lo,
                                                  input int unsigned hi);
      if (int'(v) < int'(lo)) return LOG_W'(lo);
      if (int'(v) > int'(hi)) return LOG_W'(hi);
      return v;
   endfunction

   // Segment-to-group table of the narrow window.
   logic [GRP_W-1:0] tbl_q [SEG_COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(SEG_COUNT); i++) tbl_q[i] <= '0;
      end else if (cfg_we && rgn == RGN_TABLE) begin
         tbl_q[idx[SEG_BITS-1:0]] <= cfg_wdata[GRP_W-1:0];
      end
   end

   assign tbl_grp = tbl_q[tbl_idx];

   // Wide window registers, one set per window.
   for (genvar w = 0; w < int'(NUM_WIN64); w++) begin : g_w64
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            w64_base[w] <= '0;
            w64_log[w]  <= LOG_W'(W64_MIN_LOG);
            w64_seg[w]  <= 1'b0;
            w64_en[w]   <= 1'b0;
            w64_grp[w]  <= '0;
         end else if (cfg_we && idx == IDX_W'(w)) begin
            if (rgn == RGN_W64_BASE) begin
               w64_base[w] <= cfg_wdata;
            end else if (rgn == RGN_W64_CTRL) begin
               w64_log[w] <= clamp_log(cfg_wdata[LOG_W-1:0], W64_MIN_LOG, ADDR_W);
               w64_seg[w] <= cfg_wdata[LOG_W];
               w64_en[w]  <= cfg_wdata[LOG_W+1];
               w64_grp[w] <= cfg_wdata[LOG_W+2 +: GRP_W];
            end
         end
      end

      assert_w64_log_range_R9 : assert property (@(posedge clk) disable iff (!rst_n)
         (int'(w64_log[w]) >= int'(W64_MIN_LOG)) && (int'(w64_log[w]) <= int'(ADDR_W)));
   end

   // Narrow window registers.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w32_base  <= '0;
         w32_log   <= LOG_W'(SEG_BITS);
         w32_en    <= 1'b0;
         w32_remap <= '0;
      end else if (cfg_we && rgn == RGN_W32) begin
         if (idx == IDX_W'(W32_SUB_BASE)) begin
            w32_base <= cfg_wdata;
         end else if (idx == IDX_W'(W32_SUB_CTRL)) begin
            w32_log <= clamp_log(cfg_wdata[LOG_W-1:0], SEG_BITS, W32_LOG_MAX);
            w32_en  <= cfg_wdata[LOG_W];
         end else if (idx == IDX_W'(W32_SUB_REMAP)) begin
            w32_remap <= cfg_wdata[W32_LOG_MAX-1:0];
         end
      end
   end

   assert_w32_log_range_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (int'(w32_log) >= int'(SEG_BITS)) && (int'(w32_log) <= int'(W32_LOG_MAX)));

endmodule

// File: rtl/mmwd_win64_match.sv
module mmwd_win64_match #(
   parameter int unsigned ADDR_W   = 50,
   parameter int unsigned SEG_BITS = 8,
   parameter int unsigned GRP_W    = 8,
   parameter int unsigned LOG_W    = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [LOG_W-1:0]  log2sz,
   input  logic              seg_mode,
   input  logic              enable,
   input  logic [GRP_W-1:0]  grp,
   output logic              hit,
   output logic [GRP_W-1:0]  grp_out
);

   logic [ADDR_W:0]     span_mask;
   logic [ADDR_W-1:0]   diff;
   logic [LOG_W-1:0]    shamt;
   logic [ADDR_W-1:0]   shifted;
   logic [SEG_BITS-1:0] seg_idx;

   // Bits at and above log2sz must agree with the base; lower base bits are ignored.
   assign span_mask = {(ADDR_W+1){1'b1}} << log2sz;
   assign diff      = addr ^ base;
   assign hit       = enable && ((diff & span_mask[ADDR_W-1:0]) == '0);

   // Segment index: the SEG_BITS address bits just below the window size.
   assign shamt   = log2sz - LOG_W'(SEG_BITS);
   assign shifted = addr >> shamt;
   assign seg_idx = shifted[SEG_BITS-1:0];

   assign grp_out = seg_mode ? GRP_W'(seg_idx) : grp;

endmodule

// File: rtl/mmwd_win32_match.sv
module mmwd_win32_match #(
   parameter int unsigned ADDR_W      = 50,
   parameter int unsigned SEG_BITS    = 8,
   parameter int unsigned W32_LOG_MAX = 32,
   parameter int unsigned LOG_W       = 6
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic [ADDR_W-1:0]      base,
   input  logic [LOG_W-1:0]       log2sz,
   input  logic                   enable,
   input  logic [W32_LOG_MAX-1:0] remap,
   output logic                   hit,
   output logic [SEG_BITS-1:0]    seg_idx,
   output logic [ADDR_W-1:0]      bus_addr
);

   logic [ADDR_W:0]   span_mask;
   logic [ADDR_W-1:0] hi_mask;
   logic [ADDR_W-1:0] remap_ext;
   logic [ADDR_W-1:0] shifted;
   logic [LOG_W-1:0]  shamt;

   assign span_mask = {(ADDR_W+1){1'b1}} << log2sz;
   assign hi_mask   = span_mask[ADDR_W-1:0];
   assign hit       = enable && (((addr ^ base) & hi_mask) == '0);

   assign shamt   = log2sz - LOG_W'(SEG_BITS);
   assign shifted = addr >> shamt;
   assign seg_idx = shifted[SEG_BITS-1:0];

   // Upper bits come from the remap value, offset bits from the address.
   assign remap_ext = ADDR_W'(remap);
   assign bus_addr  = (remap_ext & hi_mask) | (addr & ~hi_mask);

endmodule

// File: rtl/mmwd_pick_first.sv
module mmwd_pick_first #(
   parameter int unsigned N     = 16,
   parameter int unsigned WIN_W = 4
) (
   input  logic [N-1:0]     hits,
   output logic             any,
   output logic [WIN_W-1:0] idx,
   output logic [N-1:0]     grant
);

   assign any = |hits;

   if (N == 1) begin : g_single
      assign idx   = '0;
      assign grant = hits;
   end else begin : g_multi
      // Scan from the top so the lowest-numbered hit is assigned last.
      always_comb begin
         idx   = '0;
         grant = '0;
         for (int i = int'(N) - 1; i >= 0; i--) begin
            if (hits[i]) begin
               idx      = WIN_W'(i);
               grant    = '0;
               grant[i] = 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mmio_window_decoder.sv
module mmio_window_decoder
   import mmwd_pkg::*;
#(
   parameter int unsigned ADDR_W      = 50,
   parameter int unsigned NUM_WIN64   = 16,
   parameter int unsigned SEG_BITS    = 8,
   parameter int unsigned GRP_W       = 8,
   parameter int unsigned W32_LOG_MAX = 32,
   parameter int unsigned W64_MIN_LOG = 28,
   localparam int unsigned LOG_W      = $clog2(ADDR_W + 1),
   localparam int unsigned WIN_W      = (NUM_WIN64 > 1) ? $clog2(NUM_WIN64) : 1,
   localparam int unsigned IDX_W      = max_u(SEG_BITS, WIN_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W+1:0]  cfg_addr,
   input  logic [ADDR_W-1:0] cfg_wdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic              resp_wide,
   output logic [WIN_W-1:0]  resp_win,
   output logic [GRP_W-1:0]  resp_group,
   output logic [ADDR_W-1:0] resp_bus_addr
);

   // Elaboration-time parameter checks.
   if (GRP_W < SEG_BITS) begin : g_chk_grp
      $error("GRP_W must hold a segment index");
   end
   if (W64_MIN_LOG < SEG_BITS || W64_MIN_LOG > ADDR_W) begin : g_chk_min
      $error("W64_MIN_LOG out of range");
   end
   if (W32_LOG_MAX < SEG_BITS || W32_LOG_MAX > ADDR_W) begin : g_chk_w32
      $error("W32_LOG_MAX out of range");
   end
   if (ADDR_W < LOG_W + 2 + GRP_W) begin : g_chk_ctrl
      $error("ADDR_W too narrow for control fields");
   end

   logic [NUM_WIN64-1:0][ADDR_W-1:0] w64_base;
   logic [NUM_WIN64-1:0][LOG_W-1:0]  w64_log;
   logic [NUM_WIN64-1:0]             w64_seg;
   logic [NUM_WIN64-1:0]             w64_en;
   logic [NUM_WIN64-1:0][GRP_W-1:0]  w64_grp;
   logic [ADDR_W-1:0]                w32_base;
   logic [LOG_W-1:0]                 w32_log;
   logic                             w32_en;
   logic [W32_LOG_MAX-1:0]           w32_remap;
   logic [SEG_BITS-1:0]              w32_seg;
   logic [GRP_W-1:0]                 w32_grp;
   logic                             w32_hit;
   logic [ADDR_W-1:0]                w32_bus;

   logic [NUM_WIN64-1:0]             w64_hit;
   logic [NUM_WIN64-1:0][GRP_W-1:0]  w64_grp_out;
   logic [NUM_WIN64-1:0]             w64_grant;
   logic                             w64_any;
   logic [WIN_W-1:0]                 w64_idx;

   mmwd_cfg_regs #(
      .ADDR_W(ADDR_W), .NUM_WIN64(NUM_WIN64), .SEG_BITS(SEG_BITS),
      .GRP_W(GRP_W), .W32_LOG_MAX(W32_LOG_MAX), .W64_MIN_LOG(W64_MIN_LOG)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .tbl_idx(w32_seg), .tbl_grp(w32_grp),
      .w64_base(w64_base), .w64_log(w64_log), .w64_seg(w64_seg),
      .w64_en(w64_en), .w64_grp(w64_grp),
      .w32_base(w32_base), .w32_log(w32_log), .w32_en(w32_en),
      .w32_remap(w32_remap)
   );

   for (genvar w = 0; w < int'(NUM_WIN64); w++) begin : g_match
      mmwd_win64_match #(
         .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .GRP_W(GRP_W), .LOG_W(LOG_W)
      ) u_m64 (
         .addr(req_addr), .base(w64_base[w]), .log2sz(w64_log[w]),
         .seg_mode(w64_seg[w]), .enable(w64_en[w]), .grp(w64_grp[w]),
         .hit(w64_hit[w]), .grp_out(w64_grp_out[w])
      );
   end

   mmwd_win32_match #(
      .ADDR_W(ADDR_W), .SEG_BITS(SEG_BITS), .W32_LOG_MAX(W32_LOG_MAX), .LOG_W(LOG_W)
   ) u_m32 (
      .addr(req_addr), .base(w32_base), .log2sz(w32_log), .enable(w32_en),
      .remap(w32_remap), .hit(w32_hit), .seg_idx(w32_seg), .bus_addr(w32_bus)
   );

   mmwd_pick_first #(.N(NUM_WIN64), .WIN_W(WIN_W)) u_pick (
      .hits(w64_hit), .any(w64_any), .idx(w64_idx), .grant(w64_grant)
   );

   // Result register: wide hits outrank the narrow window.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         resp_valid    <= 1'b0;
         resp_hit      <= 1'b0;
         resp_wide     <= 1'b0;
         resp_win      <= '0;
         resp_group    <= '0;
         resp_bus_addr <= '0;
      end else begin
         resp_valid <= req_valid;
         if (w64_any) begin
            resp_hit      <= 1'b1;
            resp_wide     <= 1'b1;
            resp_win      <= w64_idx;
            resp_group    <= w64_grp_out[w64_idx];
            resp_bus_addr <= req_addr;
         end else if (w32_hit) begin
            resp_hit      <= 1'b1;
            resp_wide     <= 1'b0;
            resp_win      <= '0;
            resp_group    <= w32_grp;
            resp_bus_addr <= w32_bus;
         end else begin
            resp_hit      <= 1'b0;
            resp_wide     <= 1'b0;
            resp_win      <= '0;
            resp_group    <= '0;
            resp_bus_addr <= '0;
         end
      end
   end

   assert_grant_single_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(w64_grant));

   assert_grant_in_hits_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (w64_grant & ~w64_hit) == '0);

   assert_grant_when_hit_R7 : assert property (@(posedge clk) disable iff (!rst_n)
      (w64_hit != '0) |-> (w64_grant != '0));

   assert_valid_follows_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid);

   assert_miss_clean_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && !resp_hit) |-> (resp_group == '0 && resp_bus_addr == '0 && !resp_wide));

   assert_wide_untranslated_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && w64_any) |=> (resp_wide && resp_bus_addr == $past(req_addr)));

endmodule

// File: tb/mmio_window_decoder_test.sv
module mmio_window_decoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int AW   = 16;
   localparam int NW   = 4;
   localparam int SB   = 3;
   localparam int GW   = 4;
   localparam int W32M = 12;
   localparam int W64M = 8;
   localparam int LOGW = 5;
   localparam int WINW = 2;
   localparam int IDXW = 3;
   localparam int NSEG = 1 << SB;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            cfg_we = 1'b0;
   logic [IDXW+1:0] cfg_addr = '0;
   logic [AW-1:0]   cfg_wdata = '0;
   logic            req_valid = 1'b0;
   logic [AW-1:0]   req_addr = '0;
   logic            resp_valid;
   logic            resp_hit;
   logic            resp_wide;
   logic [WINW-1:0] resp_win;
   logic [GW-1:0]   resp_group;
   logic [AW-1:0]   resp_bus_addr;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // Bench-side copy of the programmed configuration.
   int b64[NW], l64[NW], s64[NW], e64[NW], g64[NW];
   int b32, l32, e32, r32;
   int tbl[NSEG];

   mmio_window_decoder #(
      .ADDR_W(AW), .NUM_WIN64(NW), .SEG_BITS(SB), .GRP_W(GW),
      .W32_LOG_MAX(W32M), .W64_MIN_LOG(W64M)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_addr(req_addr),
      .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_wide(resp_wide),
      .resp_win(resp_win), .resp_group(resp_group), .resp_bus_addr(resp_bus_addr)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic int clampi(input int v, input int lo, input int hi);
      if (v < lo) return lo;
      if (v > hi) return hi;
      return v;
   endfunction

   // R13 register encoding: {region, index}; control field layout per requirement.
   task automatic cfg_write(input int rg, input int idx, input int d);
      cfg_we    = 1'b1;
      cfg_addr  = (IDXW+2)'((rg << IDXW) | idx);
      cfg_wdata = AW'(d);
      @(negedge clk);
      cfg_we = 1'b0;
      case (rg)
         0: tbl[idx] = d & 15;
         1: b64[idx] = d & 16'hFFFF;
         2: begin
            l64[idx] = clampi(d & 31, W64M, AW);
            s64[idx] = (d >> 5) & 1;
            e64[idx] = (d >> 6) & 1;
            g64[idx] = (d >> 7) & 15;
         end
         default: begin
            if (idx == 0) b32 = d & 16'hFFFF;
            else if (idx == 1) begin
               l32 = clampi(d & 31, SB, W32M);
               e32 = (d >> 5) & 1;
            end else r32 = d & 12'hFFF;
         end
      endcase
   endtask

   task automatic model(input int a, output int eh, output int ew, output int ewin,
                        output int eg, output int eb, output string tag);
      eh = 0; ew = 0; ewin = 0; eg = 0; eb = 0; tag = "R8";
      for (int w = 0; w < NW; w++) begin
         if (eh == 0 && e64[w] != 0) begin
            int sz, bal;
            sz  = 1 << l64[w];
            bal = (b64[w] / sz) * sz;
            if (a >= bal && a < bal + sz) begin
               eh = 1; ew = 1; ewin = w; eb = a;
               eg  = (s64[w] != 0) ? (a - bal) / (sz / NSEG) : g64[w];
               tag = (s64[w] != 0) ? "R6" : "R5";
            end
         end
      end
      if (eh == 0 && e32 != 0) begin
         int sz, bal;
         sz  = 1 << l32;
         bal = (b32 / sz) * sz;
         if (a >= bal && a < bal + sz) begin
            eh = 1;
            eg  = tbl[(a - bal) / (sz / NSEG)];
            eb  = (r32 / sz) * sz + (a - bal);
            tag = "R3 R4";
         end
      end
   endtask

   // Called just after a falling edge; drives, waits one cycle, samples at the next falling edge.
   task automatic check_at(input int a, input string tag_in);
      int eh, ew, ewin, eg, eb;
      string tag;
      model(a, eh, ew, ewin, eg, eb, tag);
      if (tag_in != "") tag = tag_in;
      req_valid = 1'b1;
      req_addr  = AW'(a);
      @(negedge clk);
      checks++;
      if (resp_valid !== 1'b1 || resp_hit !== 1'(eh) || resp_wide !== 1'(ew) ||
          resp_win !== WINW'(ewin) || resp_group !== GW'(eg) || resp_bus_addr !== AW'(eb)) begin
         errors++;
         $display("FAIL %s addr=%h got v=%b hit=%b wide=%b win=%0d grp=%0d bus=%h exp v=1 hit=%0d wide=%0d win=%0d grp=%0d bus=%h",
                  tag, a, resp_valid, resp_hit, resp_wide, resp_win, resp_group, resp_bus_addr,
                  eh, ew, ewin, eg, eb);
      end
   endtask

   initial begin
      for (int w = 0; w < NW; w++) begin
         b64[w] = 0; l64[w] = W64M; s64[w] = 0; e64[w] = 0; g64[w] = 0;
      end
      for (int i = 0; i < NSEG; i++) tbl[i] = 0;
      b32 = 0; l32 = SB; e32 = 0; r32 = 0;

      repeat (3) @(negedge clk);
      checks++;
      if (resp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R1 resp_valid in reset got=%b exp=0", resp_valid);
      end
      rst_n = 1'b1;
      @(negedge clk);
      check_at(16'h1234, "R1");
      check_at(16'hFFFF, "R1");

      // Configuration A: overlapping wide windows, a disabled covering window.
      for (int i = 0; i < NSEG; i++) cfg_write(0, i, (i * 5 + 3) & 15);
      cfg_write(3, 0, 16'h3800);
      cfg_write(3, 1, 11 | (1 << 5));
      cfg_write(3, 2, 16'h0800);
      cfg_write(1, 0, 16'h8000);
      cfg_write(2, 0, 12 | (1 << 5) | (1 << 6));
      cfg_write(1, 1, 16'h8000);
      cfg_write(2, 1, 15 | (1 << 6) | (5 << 7));
      cfg_write(1, 2, 16'h3A00);
      cfg_write(2, 2, 9 | (1 << 6) | (9 << 7));
      cfg_write(1, 3, 16'h0000);
      cfg_write(2, 3, 16 | (3 << 7));

      for (int a = 0; a < 65536; a++) check_at(a, "");

      check_at(16'h8123, "R7");
      check_at(16'h9000, "R7");
      check_at(16'h3A10, "R7");
      check_at(16'h3FFF, "R11");
      check_at(16'h3F00, "R11");
      check_at(16'h0010, "R12");

      // Configuration B: clamped sizes, unaligned bases, window 0 switched off.
      cfg_write(3, 0, 16'h5123);
      cfg_write(3, 1, 20 | (1 << 5));
      cfg_write(3, 2, 16'h0ABC);
      cfg_write(2, 0, 12);
      cfg_write(1, 3, 16'h1234);
      cfg_write(2, 3, 2 | (1 << 5) | (1 << 6));

      for (int a = 0; a < 65536; a += 4) check_at(a, "");

      check_at(16'h1200, "R9");
      check_at(16'h12FF, "R9");
      check_at(16'h1300, "R9");
      check_at(16'h5FFF, "R9");
      check_at(16'h5000, "R10");
      check_at(16'h4FFF, "R10");
      check_at(16'h8123, "R12");

      // R2: result valid drops one cycle after requests stop.
      req_valid = 1'b0;
      @(negedge clk);
      checks++;
      if (resp_valid !== 1'b0) begin
         errors++;
         $display("FAIL R2 resp_valid after idle got=%b exp=0", resp_valid);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired got=running exp=finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule